// File: doc/BRIEF.md
# Single-Bit Phase Servo Detector

This block drives a bang-bang oscillator discipline loop from a one-bit phase detector. Each time the once-per-second strobe arrives, a flop captures the current level of a reference square wave. The reference comes from the local oscillator, either at full rate or divided down by a selectable ratio. Two further stages, advanced only by the same strobe, resynchronise that captured level. An accumulator counts the ones that emerge over a window of N strobes. At the end of each window it reports how far the count is from N/2.

That distance is the correction. It is a signed value, clamped to a fixed magnitude, together with a direction code and a one-cycle valid strobe. The loop drives the long-run fraction of ones toward one half. Near the balance point the correction is proportional. Far from it the correction saturates but still carries the sign of the error. An enable input lets the surrounding logic pause the loop: while it is low, strobes are not counted and the correction reads zero.

Top module: `phs_servo_det`

## Requirements
- R1: While reset is high, and on the first cycle after it, corr is 0, corr_vld is 0 and corr_dir is 2'b00.
- R2: On each cycle where pps_stb is high, the reference level is captured. ratio_sel picks the reference. 2'b00 gives osc_in delayed by one clock. 2'b01 gives a square wave that toggles on every rising edge of osc_in. 2'b10 and 2'b11 give one that toggles on every fifth rising edge. Both dividers start low after reset.
- R3: The level counted at strobe k is the level captured at strobe k-3 (one capture stage plus two resynchronising stages). The first three strobes after reset add nothing to the window.
- R4: The window length is N = 2^win_sel strobes that carry a counted level. win_sel values below 2 act as 2 and values above 8 act as 8.
- R5: When a strobe completes a window, corr becomes clamp(ones - N/2, -CORR_MAX, +CORR_MAX) on the next cycle, and corr_vld is high for exactly that one cycle.
- R6: Between window ends corr keeps its value, and corr_vld stays low. The ones and strobe counts restart from zero after each window.
- R7: corr_dir is 2'b01 (up) when corr > 0, 2'b10 (down) when corr < 0, and 2'b00 (hold) when corr = 0.
- R8: While en is low, strobes are not counted, corr and corr_dir read zero, and corr_vld stays low. The capture and resynchronising stages keep advancing. When en returns, the window resumes from its frozen partial counts.
- R9: When |ones - N/2| exceeds CORR_MAX, corr equals +CORR_MAX or -CORR_MAX, with the sign of ones - N/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable; low freezes the window and zeroes the correction |
| pps_stb | input | 1 | One-cycle strobe marking the once-per-second edge |
| osc_in | input | 1 | Oscillator square wave, oversampled by clk |
| ratio_sel | input | 2 | Reference select: 00 full, 01 divide by 2, 10/11 divide by 10 |
| win_sel | input | 4 | log2 of the window length, clamped to 2..8 |
| corr | output | 6 | Signed, clamped correction from the last window |
| corr_vld | output | 1 | One-cycle strobe when corr is updated |
| corr_dir | output | 2 | Direction code: 00 hold, 01 up, 10 down |

## Verification
A free-running reference sampled at irregular strobe spacing yields mixed bit streams. With these, the counted result depends on both the three-strobe lag and the divider phase, so an error in either shows up as a wrong correction value. A reference held high or low produces all-ones or all-zeros windows. These drive the correction past the clamp in both directions and separate saturation from plain subtraction. Strobes spaced at half the oscillator period give a strictly alternating bit, which must settle to an exact zero and a hold code. A run with a disabled stretch in mid-window separates frozen partial counts from counts that were restarted or that kept running.

// File: rtl/phs_pkg.sv
package phs_pkg;

    typedef enum logic [1:0] {
        RATIO_FULL  = 2'b00,
        RATIO_HALF  = 2'b01,
        RATIO_TENTH = 2'b10,
        RATIO_ALT   = 2'b11
    } ratio_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } dir_e;

    // One captured level travelling down the strobe-clocked pipeline
    typedef struct packed {
        logic vld;
        logic level;
    } tap_t;

    function automatic int clamp_mag(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic int clamp_range(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic dir_e dir_of(input int v);
        if (v > 0) return DIR_UP;
        if (v < 0) return DIR_DOWN;
        return DIR_HOLD;
    endfunction

endpackage

// File: rtl/phs_refdiv.sv
module phs_refdiv
    import phs_pkg::*;
#(
    parameter int DIV_MID = 2,
    parameter int DIV_LOW = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_in,
    input  logic [1:0] ratio_sel,
    output logic       ref_o
);
    localparam int NDIV = 2;
    localparam int DCW  = (DIV_LOW > 2) ? $clog2(DIV_LOW) : 1;

    logic            osc_q;
    logic            rise;
    logic [NDIV-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) osc_q <= 1'b0;
        else     osc_q <= osc_in;
    end

    assign rise = osc_in & ~osc_q;

    // One toggling divider per selectable ratio
    for (genvar g = 0; g < NDIV; g++) begin : g_div
        localparam int HALF = ((g == 0) ? DIV_MID : DIV_LOW) / 2;
        logic [DCW-1:0] cnt_q;
        logic           tgl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                tgl_q <= 1'b0;
            end else if (rise) begin
                if (cnt_q == DCW'(HALF - 1)) begin
                    cnt_q <= '0;
                    tgl_q <= ~tgl_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        assign div_q[g] = tgl_q;
    end

    always_comb begin
        unique case (ratio_e'(ratio_sel))
            RATIO_FULL: ref_o = osc_q;
            RATIO_HALF: ref_o = div_q[0];
            default:    ref_o = div_q[1];
        endcase
    end

endmodule

// File: rtl/phs_sampler.sv
module phs_sampler
    import phs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps,
    input  logic ref_i,
    output tap_t tap_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    tap_t pipe [DEPTH];

    // Capture flop followed by resynchronising stages, all advanced by the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else if (pps) begin
            pipe[0] <= '{vld: 1'b1, level: ref_i};
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign tap_o = pipe[DEPTH-1];

endmodule

// File: rtl/phs_window.sv
module phs_window
    import phs_pkg::*;
#(
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 8,
    parameter int CORR_MAX = 16,
    parameter int WSEL_W   = 4,
    parameter int CORR_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     pps,
    input  tap_t                     tap_i,
    input  logic [WSEL_W-1:0]        win_sel,
    output logic signed [CORR_W-1:0] corr,
    output logic                     corr_vld,
    output logic [1:0]               corr_dir
);
    localparam int CNT_W = MAX_LOG2 + 1;

    logic [CNT_W-1:0]         pulses_q, ones_q, ones_nx, last_idx;
    logic                     take;
    int                       eff_log2, half_n, lim_v;
    logic signed [CORR_W-1:0] corr_q;
    dir_e                     dir_q;
    logic                     vld_q;

    always_comb begin
        eff_log2 = clamp_range(int'(win_sel), MIN_LOG2, MAX_LOG2);
        last_idx = CNT_W'((1 << eff_log2) - 1);
        half_n   = (1 << eff_log2) / 2;
        take     = pps && en && tap_i.vld;
        ones_nx  = ones_q + CNT_W'(tap_i.level);
        lim_v    = clamp_mag(int'(ones_nx) - half_n, CORR_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses_q <= '0;
            ones_q   <= '0;
            corr_q   <= '0;
            dir_q    <= DIR_HOLD;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (!en) begin
                corr_q <= '0;
                dir_q  <= DIR_HOLD;
            end else if (take) begin
                if (pulses_q == last_idx) begin
                    corr_q   <= CORR_W'(lim_v);
                    dir_q    <= dir_of(lim_v);
                    vld_q    <= 1'b1;
                    pulses_q <= '0;
                    ones_q   <= '0;
                end else begin
                    pulses_q <= pulses_q + 1'b1;
                    ones_q   <= ones_nx;
                end
            end
        end
    end

    assign corr     = corr_q;
    assign corr_vld = vld_q;
    assign corr_dir = dir_q;

endmodule

// File: rtl/phs_servo_det.sv
module phs_servo_det
    import phs_pkg::*;
#(
    parameter  int MIN_LOG2    = 2,
    parameter  int MAX_LOG2    = 8,
    parameter  int CORR_MAX    = 16,
    parameter  int SYNC_STAGES = 2,
    parameter  int DIV_MID     = 2,
    parameter  int DIV_LOW     = 10,
    localparam int WSEL_W      = $clog2(MAX_LOG2 + 1),
    localparam int CORR_W      = $clog2(CORR_MAX + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     pps_stb,
    input  logic                     osc_in,
    input  logic [1:0]               ratio_sel,
    input  logic [WSEL_W-1:0]        win_sel,
    output logic signed [CORR_W-1:0] corr,
    output logic                     corr_vld,
    output logic [1:0]               corr_dir
);
    logic ref_lvl;
    tap_t tap;

    phs_refdiv #(.DIV_MID(DIV_MID), .DIV_LOW(DIV_LOW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .osc_in    (osc_in),
        .ratio_sel (ratio_sel),
        .ref_o     (ref_lvl)
    );

    phs_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk   (clk),
        .rst   (rst),
        .pps   (pps_stb),
        .ref_i (ref_lvl),
        .tap_o (tap)
    );

    phs_window #(
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2),
        .CORR_MAX (CORR_MAX),
        .WSEL_W   (WSEL_W),
        .CORR_W   (CORR_W)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .pps      (pps_stb),
        .tap_i    (tap),
        .win_sel  (win_sel),
        .corr     (corr),
        .corr_vld (corr_vld),
        .corr_dir (corr_dir)
    );

endmodule

// File: rtl/phs_servo_chk.sv
module phs_servo_chk #(
    parameter int CORR_MAX = 16,
    parameter int CORR_W   = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic                     pps_stb,
    input logic signed [CORR_W-1:0] corr,
    input logic                     corr_vld,
    input logic [1:0]               corr_dir
);
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        corr_vld |=> !corr_vld); // R6

    AST_VLD_FROM_PULSE: assert property (@(posedge clk) disable iff (rst)
        corr_vld |-> ($past(pps_stb) && $past(en))); // R5

    AST_CORR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (corr <= CORR_MAX) && (corr >= -CORR_MAX)); // R9

    AST_CORR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!corr_vld && $past(en)) |-> $stable(corr)); // R6

    AST_DIS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (corr == 0 && corr_dir == 2'b00 && !corr_vld)); // R8

    AST_DIR_SIGN: assert property (@(posedge clk) disable iff (rst)
        corr_dir == ((corr > 0) ? 2'b01 : (corr < 0) ? 2'b10 : 2'b00)); // R7

endmodule

bind phs_servo_det phs_servo_chk #(.CORR_MAX(CORR_MAX), .CORR_W(CORR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .pps_stb  (pps_stb),
    .corr     (corr),
    .corr_vld (corr_vld),
    .corr_dir (corr_dir)
);

// File: tb/tb_phs_servo_det.sv
module tb_phs_servo_det;
    localparam int CMAX   = 16;
    localparam int CW     = $clog2(CMAX + 1) + 1;
    localparam int HALF_P = 3;

    logic                 clk = 1'b0;
    logic                 rst, en, pps_stb, osc_in;
    logic [1:0]           ratio_sel;
    logic [3:0]           win_sel;
    logic signed [CW-1:0] corr;
    logic                 corr_vld;
    logic [1:0]           corr_dir;

    int n_tests = 0, n_fail = 0;
    int osc_mode, ph, rises;
    logic mp_lvl [3];
    logic mp_vld [3];
    int m_pulses, m_ones, exp_corr;
    logic exp_vld;
    string tag;

    phs_servo_det dut (
        .clk(clk), .rst(rst), .en(en), .pps_stb(pps_stb), .osc_in(osc_in),
        .ratio_sel(ratio_sel), .win_sel(win_sel),
        .corr(corr), .corr_vld(corr_vld), .corr_dir(corr_dir)
    );

    always #4 clk = ~clk;

    function automatic int win_n();
        int w = int'(win_sel);
        if (w < 2) w = 2;
        if (w > 8) w = 8;
        return 1 << w;
    endfunction

    function automatic logic [1:0] dir_exp(input int v);
        return (v > 0) ? 2'b01 : (v < 0) ? 2'b10 : 2'b00;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R5", int'(corr), exp_corr);
        chk("R6", int'(corr_vld), int'(exp_vld));
        chk("R7", int'(corr_dir), int'(dir_exp(exp_corr)));
    endtask

    // One clock: check last edge, then drive inputs and advance the model
    task automatic tick(input logic p);
        logic r;
        int n, o, d;
        @(negedge clk);
        check_outputs();
        case (ratio_sel)
            2'b00:   r = osc_in;
            2'b01:   r = logic'(rises % 2);
            default: r = logic'((rises / 5) % 2);
        endcase
        pps_stb = p;
        exp_vld = 1'b0;
        if (!en) begin
            exp_corr = 0;
        end else if (p && mp_vld[2]) begin
            n = win_n();
            o = m_ones + int'(mp_lvl[2]);
            if (m_pulses == n - 1) begin
                d = o - n / 2;
                exp_corr = (d > CMAX) ? CMAX : (d < -CMAX) ? -CMAX : d;
                exp_vld  = 1'b1;
                m_pulses = 0;
                m_ones   = 0;
            end else begin
                m_pulses++;
                m_ones = o;
            end
        end
        if (p) begin
            mp_lvl[2] = mp_lvl[1]; mp_vld[2] = mp_vld[1];
            mp_lvl[1] = mp_lvl[0]; mp_vld[1] = mp_vld[0];
            mp_lvl[0] = r;         mp_vld[0] = 1'b1;
        end
        case (osc_mode)
            0: begin
                ph++;
                if (ph == HALF_P) begin
                    ph = 0;
                    if (!osc_in) rises++;
                    osc_in = ~osc_in;
                end
            end
            1: begin
                if (!osc_in) rises++;
                osc_in = 1'b1;
            end
            default: osc_in = 1'b0;
        endcase
    endtask

    task automatic do_reset(input logic [1:0] rs, input logic [3:0] ws, input int mode);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; pps_stb = 1'b0; osc_in = 1'b0;
        ratio_sel = rs; win_sel = ws; osc_mode = mode;
        ph = 0; rises = 0; m_pulses = 0; m_ones = 0; exp_corr = 0; exp_vld = 1'b0;
        for (int i = 0; i < 3; i++) begin mp_lvl[i] = 1'b0; mp_vld[i] = 1'b0; end
        repeat (3) @(negedge clk);
        chk("R1", int'(corr), 0);
        chk("R1", int'(corr_vld), 0);
        chk("R1", int'(corr_dir), 0);
        rst = 1'b0;
    endtask

    task automatic run_pulses(input int npulse, input int gap_mode);
        for (int i = 0; i < npulse; i++) begin
            int gap = (gap_mode == 0) ? 1 + ((i * 5 + 3) % 7) : HALF_P;
            for (int g = 0; g < gap - 1; g++) tick(1'b0);
            tick(1'b1);
        end
        tick(1'b0);
        tick(1'b0);
    endtask

    task automatic phase(input string t, input logic [1:0] rs, input logic [3:0] ws,
                         input int mode, input int npulse, input int gap_mode);
        tag = t;
        do_reset(rs, ws, mode);
        run_pulses(npulse, gap_mode);
    endtask

    initial begin
        rst = 1'b1; en = 1'b1; pps_stb = 1'b0; osc_in = 1'b0;
        ratio_sel = 2'b00; win_sel = 4'd2; osc_mode = 0;
        tag = "R1 reset";

        phase("R3 full ratio N4", 2'b00, 4'd2, 0, 43, 0);
        phase("R2 divide by 2 N16", 2'b01, 4'd4, 0, 67, 0);
        phase("R2 divide by 10 N8", 2'b10, 4'd3, 0, 59, 0);
        phase("R2 code 11 N8", 2'b11, 4'd3, 0, 35, 0);
        phase("R4 balanced N8", 2'b00, 4'd3, 0, 35, 1);

        phase("R9 stuck high N64", 2'b00, 4'd6, 1, 67, 0);
        chk("R9", int'(corr), CMAX);
        phase("R9 stuck low N256", 2'b00, 4'd8, 2, 259, 0);
        chk("R9", int'(corr), -CMAX);

        phase("R4 win_sel 0 acts as 2", 2'b00, 4'd0, 1, 11, 0);
        chk("R4", int'(corr), 2);
        phase("R4 win_sel 15 acts as 8", 2'b00, 4'd15, 1, 259, 0);
        chk("R4", int'(corr), CMAX);

        // R8: disabled stretch in mid-window, partial counts must be kept
        tag = "R8 enable freeze";
        do_reset(2'b00, 4'd2, 1);
        run_pulses(5, 0);
        en = 1'b0;
        run_pulses(4, 0);
        chk("R8", int'(corr), 0);
        en = 1'b1;
        run_pulses(2, 0);
        chk("R8", int'(corr), 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule